// File: doc/BRIEF.md
# Asymmetric-Width Dual-Clock RAM

This block is a simple dual-port memory with a narrow write port and a wide read port, each on its own clock. The storage rows are as wide as the read port. Each narrow write updates a single lane of one row. The low bits of the narrow address pick the lane and the upper bits pick the row, so a write never touches more than one row in a clock.

The read port takes a row address and a read enable. It returns the whole row through an output register one read-clock edge later. Each port has its own synchronous active-high reset. The read reset clears the output register. The write reset blocks writes. The storage itself is not cleared.

A typical use collects narrow samples on one clock and drains them as wide words on another. The producer fills every lane of a row before the consumer reads that row.

Top module: `amem_asym_ram`

## Requirements
- R1: A row holds NARROW_W*RATIO bits (64 by default), and one read returns all of them on rd_data.
- R2: The low log2(RATIO) bits of wr_addr select the lane. The remaining upper bits select the row, so wr_addr = row*RATIO + lane.
- R3: Lane k occupies row bits [k*NARROW_W +: NARROW_W], and lane 0 holds the least significant bits.
- R4: A write with wr_en high stores wr_data into the selected lane of the selected row. The other lanes of that row and all other rows keep their contents.
- R5: A wr_clk edge with wr_en low changes no storage.
- R6: When rd_en is high at a rd_clk edge, rd_data shows the row at rd_addr right after that edge. Before that edge it still shows its previous value.
- R7: When rd_en is low at a rd_clk edge, rd_data keeps its value even if rd_addr changes.
- R8: When rd_rst is high at a rd_clk edge, rd_data becomes zero, even if rd_en is high.
- R9: While wr_rst is high, a write with wr_en high changes no storage.
- R10: The lowest narrow address (0) and the highest (NARROW_DEPTH-1) reach lane 0 of row 0 and the last lane of the last row. A completed write is visible to a later read, even though the two clocks are unrelated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| wr_rst | input | 1 | Synchronous active-high write reset; blocks writes |
| wr_en | input | 1 | Write enable |
| wr_addr | input | NADDR_W (9) | Narrow address: row in the upper bits, lane in the low bits |
| wr_data | input | NARROW_W (16) | Lane data to store |
| rd_clk | input | 1 | Read-port clock |
| rd_rst | input | 1 | Synchronous active-high read reset; clears rd_data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ROW_BITS (7) | Row address for reading |
| rd_data | output | WIDE_W (64) | Registered wide read data |

## Verification
The storage assertions assume that the write-port inputs are stable around wr_clk edges. They check lane contents one write-clock edge after a write, in terms of the row and mask captured at that edge. The read assertions assume that the row being read is not written in the same interval. A read and a write of the same row from the two domains would give an undefined value. The stimulus runs writes and reads one after the other from a single sequence. Every write completes before the read that depends on it is issued, and inputs change only on falling clock edges, so every read lands on settled storage.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int DEF_NARROW_W   = 16;
    localparam int DEF_RATIO      = 4;
    localparam int DEF_WIDE_DEPTH = 128;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int wide_width(input int narrow_w, input int ratio);
        return narrow_w * ratio;
    endfunction

endpackage

// File: rtl/amem_lane_dec.sv
module amem_lane_dec #(
    parameter int RATIO     = 4,
    parameter int LANE_BITS = 2,
    parameter int ROW_BITS  = 7,
    parameter int NADDR_W   = ROW_BITS + LANE_BITS
) (
    input  logic                wr_en,
    input  logic                wr_rst,
    input  logic [NADDR_W-1:0]  wr_addr,
    output logic [ROW_BITS-1:0] wr_row,
    output logic [RATIO-1:0]    lane_we
);
    logic                 go;
    logic [LANE_BITS-1:0] lane;

    assign go     = wr_en && !wr_rst;
    assign lane   = wr_addr[LANE_BITS-1:0];
    assign wr_row = wr_addr[NADDR_W-1:LANE_BITS];

    for (genvar k = 0; k < RATIO; k++) begin : g_lane
        assign lane_we[k] = go && (lane == LANE_BITS'(k));
    end
endmodule

// File: rtl/amem_store.sv
module amem_store #(
    parameter int NARROW_W   = 16,
    parameter int RATIO      = 4,
    parameter int WIDE_DEPTH = 128,
    parameter int ROW_BITS   = 7,
    parameter int WIDE_W     = NARROW_W * RATIO
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  logic [RATIO-1:0]    lane_we,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [NARROW_W-1:0] wr_data,
    input  logic [ROW_BITS-1:0] rd_row,
    output logic [WIDE_W-1:0]   rd_row_data
);
    logic [WIDE_W-1:0] mem [WIDE_DEPTH];
    logic [WIDE_W-1:0] wide_data;
    logic [WIDE_W-1:0] lane_mask;

    assign wide_data = {RATIO{wr_data}};

    for (genvar k = 0; k < RATIO; k++) begin : g_mask
        assign lane_mask[k*NARROW_W +: NARROW_W] = {NARROW_W{lane_we[k]}};
    end

    always_ff @(posedge wr_clk) begin
        for (int k = 0; k < RATIO; k++) begin
            if (lane_we[k]) mem[wr_row][k*NARROW_W +: NARROW_W] <= wr_data;
        end
    end

    assign rd_row_data = mem[rd_row];

    // R4
    lane_write_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (|lane_we) |=> ((mem[$past(wr_row)] & $past(lane_mask)) ==
                        ($past(wide_data) & $past(lane_mask))));

    // R4
    other_lanes_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (|lane_we) |=> ((mem[$past(wr_row)] & ~$past(lane_mask)) ==
                        ($past(mem[wr_row]) & ~$past(lane_mask))));

    // R5
    idle_write_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !(|lane_we) |=> (mem[$past(wr_row)] == $past(mem[wr_row])));
endmodule

// File: rtl/amem_rd_reg.sv
module amem_rd_reg #(
    parameter int WIDE_W = 64
) (
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [WIDE_W-1:0] row_data,
    output logic [WIDE_W-1:0] rd_data
);
    always_ff @(posedge rd_clk) begin
        if (rd_rst)     rd_data <= '0;
        else if (rd_en) rd_data <= row_data;
    end

    // R6
    rd_load_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_en |=> (rd_data == $past(row_data)));

    // R7
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/amem_asym_ram.sv
module amem_asym_ram
    import amem_pkg::*;
#(
    parameter int NARROW_W   = DEF_NARROW_W,
    parameter int RATIO      = DEF_RATIO,
    parameter int WIDE_DEPTH = DEF_WIDE_DEPTH,
    localparam int WIDE_W    = wide_width(NARROW_W, RATIO),
    localparam int LANE_BITS = $clog2(RATIO),
    localparam int ROW_BITS  = $clog2(WIDE_DEPTH),
    localparam int NADDR_W   = ROW_BITS + LANE_BITS
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  logic                wr_en,
    input  logic [NADDR_W-1:0]  wr_addr,
    input  logic [NARROW_W-1:0] wr_data,
    input  logic                rd_clk,
    input  logic                rd_rst,
    input  logic                rd_en,
    input  logic [ROW_BITS-1:0] rd_addr,
    output logic [WIDE_W-1:0]   rd_data
);
    if (!is_pow2(RATIO) || RATIO < 2) begin : g_bad_ratio
        $error("RATIO must be a power of two of at least 2");
    end

    logic [ROW_BITS-1:0] wr_row;
    logic [RATIO-1:0]    lane_we;
    logic [WIDE_W-1:0]   row_data;

    amem_lane_dec #(
        .RATIO(RATIO), .LANE_BITS(LANE_BITS),
        .ROW_BITS(ROW_BITS), .NADDR_W(NADDR_W)
    ) u_dec (
        .wr_en(wr_en), .wr_rst(wr_rst), .wr_addr(wr_addr),
        .wr_row(wr_row), .lane_we(lane_we)
    );

    amem_store #(
        .NARROW_W(NARROW_W), .RATIO(RATIO), .WIDE_DEPTH(WIDE_DEPTH),
        .ROW_BITS(ROW_BITS), .WIDE_W(WIDE_W)
    ) u_store (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .lane_we(lane_we),
        .wr_row(wr_row), .wr_data(wr_data),
        .rd_row(rd_addr), .rd_row_data(row_data)
    );

    amem_rd_reg #(.WIDE_W(WIDE_W)) u_rd (
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .row_data(row_data), .rd_data(rd_data)
    );
endmodule

// File: tb/amem_asym_ram_bench.sv
module amem_asym_ram_bench;
    localparam int NW = 16;
    localparam int RT = 4;
    localparam int DEPTH = 128;
    localparam int WW = NW * RT;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst = 1, rd_rst = 1;
    logic          wr_en = 0, rd_en = 0;
    logic [8:0]    wr_addr = '0;
    logic [NW-1:0] wr_data = '0;
    logic [6:0]    rd_addr = '0;
    logic [WW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    logic [WW-1:0] ref_mem [DEPTH];

    always #10 wr_clk = ~wr_clk;
    always #13 rd_clk = ~rd_clk;

    amem_asym_ram u_amem_asym_ram (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {enable, narrow address, data}
    localparam logic [25:0] VEC [12] = '{
        {1'b1, 9'd1,  16'h1111}, {1'b0, 9'd2,  16'hDEAD},
        {1'b1, 9'd7,  16'h7777}, {1'b1, 9'd8,  16'h8888},
        {1'b0, 9'd9,  16'hBEEF}, {1'b1, 9'd14, 16'hEEEE},
        {1'b1, 9'd21, 16'h2121}, {1'b0, 9'd22, 16'hF00D},
        {1'b1, 9'd40, 16'h4040}, {1'b1, 9'd43, 16'h4343},
        {1'b1, 9'd63, 16'h6363}, {1'b0, 9'd60, 16'hCAFE}
    };

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic en, input logic [8:0] a, input logic [NW-1:0] d);
        @(negedge wr_clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge wr_clk);
        wr_en = 0;
        if (en && !wr_rst) ref_mem[a[8:2]][a[1:0]*NW +: NW] = d;
    endtask

    task automatic do_read(input logic [6:0] r, output logic [WW-1:0] q);
        @(negedge rd_clk);
        rd_addr = r; rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        q = rd_data;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge wr_clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [WW-1:0] q, held;
        repeat (4) @(negedge rd_clk);
        check("R8 reset", rd_data, '0);
        wr_rst = 0; rd_rst = 0;

        // fill rows 0..15, every lane (R2, R3)
        for (int a = 0; a < 64; a++) do_write(1'b1, 9'(a), 16'(a * 16'h0101 ^ 16'h5A3C));

        // vector table (R4, R5)
        for (int i = 0; i < 12; i++) begin
            do_write(VEC[i][25], VEC[i][24:16], VEC[i][15:0]);
            do_read(VEC[i][24:18], q);
            check(VEC[i][25] ? "R4 lane write" : "R5 disabled write", q, ref_mem[VEC[i][24:18]]);
        end

        // whole rows (R1, R6)
        for (int r = 0; r < 16; r++) begin
            do_read(7'(r), q);
            check("R1 full row", q, ref_mem[r]);
        end

        // lane placement (R3)
        for (int l = 0; l < 4; l++) do_write(1'b1, 9'(80 + l), 16'h0000);
        do_write(1'b1, 9'd82, 16'hFFFF);
        do_read(7'd20, q);
        check("R3 lane 2 position", q, 64'h0000_FFFF_0000_0000);

        // latency (R6): before the sampling edge old value remains
        do_read(7'd0, held);
        @(negedge rd_clk);
        rd_addr = 7'd20; rd_en = 1;
        #1 check("R6 before edge", rd_data, held);
        @(negedge rd_clk);
        rd_en = 0;
        check("R6 after edge", rd_data, 64'h0000_FFFF_0000_0000);

        // hold (R7)
        rd_addr = 7'd1;
        repeat (3) @(negedge rd_clk);
        check("R7 hold", rd_data, 64'h0000_FFFF_0000_0000);

        // read reset priority (R8)
        @(negedge rd_clk);
        rd_rst = 1; rd_en = 1; rd_addr = 7'd0;
        @(negedge rd_clk);
        rd_rst = 0; rd_en = 0;
        check("R8 reset over enable", rd_data, '0);

        // write reset blocks writes (R9)
        wr_rst = 1;
        do_write(1'b1, 9'd0, 16'h9999);
        wr_rst = 0;
        do_read(7'd0, q);
        check("R9 write during reset", q, ref_mem[0]);

        // address extremes (R10)
        for (int l = 0; l < 4; l++) do_write(1'b1, 9'(508 + l), 16'(16'hA000 + l));
        do_write(1'b1, 9'd511, 16'h0BAD);
        do_read(7'd127, q);
        check("R10 top address", q, 64'h0BAD_A002_A001_A000);
        do_write(1'b1, 9'd0, 16'h1234);
        do_read(7'd0, q);
        check("R10 bottom address", q, ref_mem[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule